// File: doc/BRIEF.md
# Variable-Size Byte Pointer Unit

This block works on byte pointers that walk through memory made of 36-bit words, where a "byte" may be any width from 1 to 36 bits. A pointer has three fields: a word address, a position, and a byte size. The position counts the bits that lie to the right of the current byte's least significant bit, so bytes are taken from the most significant end of a word downward. Each request carries an operation code, a pointer, a memory word and store data. One clock later the block returns the updated pointer, the byte it extracted, the word with a byte merged in, and the word address the access should use. Bus sequencing stays with the caller.

An increment moves the pointer to the next byte. A byte is never split across two words: if the next byte does not fit below the current one, the pointer moves to the following word and starts again at the top. A load reads the byte the pointer names, right-justified and zero-filled. A store replaces that bit field in the supplied word and leaves every other bit as it was. A load or store does not move the pointer. The caller increments first when it wants to step to the next byte and then access it.

Top module: `byte_ptr_unit`

## Requirements
- R1: Results are registered. `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and low otherwise. Reset drives every output to zero.
- R2: Operation codes: 2'b00 pass, 2'b01 increment, 2'b10 load, 2'b11 store. Pass returns the pointer unchanged, `out_byte` zero and `out_word` equal to `in_word`.
- R3: An increment with a valid size and `in_pos >= in_size` keeps the word address and returns position `in_pos - in_size`.
- R4: An increment with a valid size and `in_pos < in_size` returns word address `in_addr + 1`, wrapping modulo 2^ADDR_W, and position `36 - in_size`.
- R5: Repeated increments starting from position 36 behave as follows.
  - 7-bit bytes give positions 29, 22, 15, 8, 1 and then 29 in the next word: five bytes per word with one bit unused.
  - 9-bit bytes give positions 27, 18, 9, 0 and then 27 in the next word: four bytes per word with no bit unused.
- R6: A load returns bits `[in_pos+in_size-1 : in_pos]` of `in_word` in the low bits of `out_byte`, with zeros above them. Field bits above bit 35 read as zero. The pointer is returned unchanged.
- R7: A store returns `in_word` with bits `[in_pos+in_size-1 : in_pos]` replaced by the low bits of `st_data`. All other bits are unchanged, field bits above bit 35 are dropped, and the pointer is returned unchanged.
- R8: A size of 0, or a size above 36, makes every operation a no-op. The pointer is unchanged, `out_byte` is 0 and `out_word` equals `in_word`.
- R9: `acc_addr` equals the word address of the incoming pointer, and `out_size` equals `in_size`, for every operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_op | input | 2 | Operation code |
| in_addr | input | ADDR_W (18) | Pointer word address |
| in_pos | input | POS_W (6) | Pointer bit position |
| in_size | input | POS_W (6) | Pointer byte size |
| in_word | input | WORD_W (36) | Memory word |
| st_data | input | WORD_W (36) | Byte to deposit, right-justified |
| out_valid | output | 1 | Result present |
| out_addr | output | ADDR_W | Updated word address |
| out_pos | output | POS_W | Updated position |
| out_size | output | POS_W | Byte size |
| out_byte | output | WORD_W | Extracted byte |
| out_word | output | WORD_W | Word with the byte merged in |
| acc_addr | output | ADDR_W | Word address to access |

## Verification
The bench builds the block with its default parameters: 36-bit words, an 18-bit word address, and 6-bit position and size fields. With 6-bit fields the bench can drive sizes and positions up to 63. That reaches the out-of-range sizes, and fields that hang over the top of the word, as well as the full 36-bit byte. The bench also starts a pointer at the top word address, which exercises the address wrap on increment.

// File: rtl/byte_ptr_unit.sv
module byte_ptr_unit #(
  parameter int WORD_W = 36,
  parameter int ADDR_W = 18,
  localparam int POS_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [POS_W-1:0]  in_pos,
  input  logic [POS_W-1:0]  in_size,
  input  logic [WORD_W-1:0] in_word,
  input  logic [WORD_W-1:0] st_data,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [POS_W-1:0]  out_pos,
  output logic [POS_W-1:0]  out_size,
  output logic [WORD_W-1:0] out_byte,
  output logic [WORD_W-1:0] out_word,
  output logic [ADDR_W-1:0] acc_addr
);
  localparam logic [1:0] OP_INC = 2'b01;
  localparam logic [1:0] OP_LD  = 2'b10;
  localparam logic [1:0] OP_ST  = 2'b11;
  localparam logic [POS_W-1:0] TOP = POS_W'(WORD_W);

  logic              size_ok, fits;
  logic [WORD_W-1:0] bmask, fmask, ext, merged;
  logic [POS_W-1:0]  nxt_pos;
  logic [ADDR_W-1:0] nxt_addr;

  assign size_ok  = (in_size != '0) && (in_size <= TOP);
  assign bmask    = size_ok ? ({WORD_W{1'b1}} >> (TOP - in_size)) : '0;
  assign fmask    = bmask << in_pos;
  assign ext      = (in_word >> in_pos) & bmask;
  assign merged   = (in_word & ~fmask) | ((st_data << in_pos) & fmask);
  assign fits     = in_pos >= in_size;
  assign nxt_pos  = fits ? in_pos - in_size : TOP - in_size;
  assign nxt_addr = fits ? in_addr : in_addr + ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_pos   <= '0;
      out_size  <= '0;
      out_byte  <= '0;
      out_word  <= '0;
      acc_addr  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_size <= in_size;
        acc_addr <= in_addr;
        out_addr <= in_addr;
        out_pos  <= in_pos;
        out_byte <= '0;
        out_word <= in_word;
        case (in_op)
          OP_INC: if (size_ok) begin
            out_addr <= nxt_addr;
            out_pos  <= nxt_pos;
          end
          OP_LD:   out_byte <= ext;
          OP_ST:   out_word <= merged;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/byte_ptr_unit_chk.sv
module byte_ptr_unit_chk #(
  parameter int WORD_W = 36,
  parameter int ADDR_W = 18,
  parameter int POS_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        in_op,
  input logic [ADDR_W-1:0] in_addr,
  input logic [POS_W-1:0]  in_pos,
  input logic [POS_W-1:0]  in_size,
  input logic [WORD_W-1:0] in_word,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr,
  input logic [POS_W-1:0]  out_pos,
  input logic [POS_W-1:0]  out_size,
  input logic [WORD_W-1:0] out_byte,
  input logic [WORD_W-1:0] out_word,
  input logic [ADDR_W-1:0] acc_addr
);
  localparam logic [POS_W-1:0] TOP = POS_W'(WORD_W);
  logic ok;
  assign ok = (in_size != '0) && (in_size <= TOP);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  a_r2_pass_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'b00) |=> (out_byte == '0 && out_word == $past(in_word)
      && out_pos == $past(in_pos) && out_addr == $past(in_addr)));

  a_r3_step_in_word: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'b01 && ok && in_pos >= in_size) |=>
      (out_addr == $past(in_addr) && out_pos == $past(in_pos) - $past(in_size)));

  a_r4_step_next_word: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'b01 && ok && in_pos < in_size) |=>
      (out_addr == $past(in_addr) + ADDR_W'(1) && out_pos == TOP - $past(in_size)));

  a_r6_load_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'b10 && ok) |=>
      ((out_byte >> $past(in_size)) == '0 && out_pos == $past(in_pos)));

  a_r7_store_ptr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'b11) |=> (out_pos == $past(in_pos) && out_addr == $past(in_addr)
      && out_byte == '0));

  a_r8_bad_size_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ok) |=> (out_byte == '0 && out_word == $past(in_word)
      && out_pos == $past(in_pos) && out_addr == $past(in_addr)));

  a_r9_addr_size: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (acc_addr == $past(in_addr) && out_size == $past(in_size)));
endmodule

bind byte_ptr_unit byte_ptr_unit_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .POS_W(POS_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_addr(in_addr),
  .in_pos(in_pos), .in_size(in_size), .in_word(in_word), .out_valid(out_valid),
  .out_addr(out_addr), .out_pos(out_pos), .out_size(out_size), .out_byte(out_byte),
  .out_word(out_word), .acc_addr(acc_addr));

// File: tb/test_byte_ptr_unit.sv
`timescale 1ns/1ps
module test_byte_ptr_unit;
  localparam int WW = 36, AW = 18, PW = 6;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [1:0] in_op = '0;
  logic [AW-1:0] in_addr = '0;
  logic [PW-1:0] in_pos = '0, in_size = '0;
  logic [WW-1:0] in_word = '0, st_data = '0;
  logic out_valid;
  logic [AW-1:0] out_addr, acc_addr;
  logic [PW-1:0] out_pos, out_size;
  logic [WW-1:0] out_byte, out_word;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  byte_ptr_unit #(.WORD_W(WW), .ADDR_W(AW)) i_byte_ptr_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_addr(in_addr),
    .in_pos(in_pos), .in_size(in_size), .in_word(in_word), .st_data(st_data),
    .out_valid(out_valid), .out_addr(out_addr), .out_pos(out_pos), .out_size(out_size),
    .out_byte(out_byte), .out_word(out_word), .acc_addr(acc_addr));

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [1:0] op, input int addr, input int pos, input int size,
                       input logic [WW-1:0] word, input logic [WW-1:0] data,
                       output int eaddr, output int epos,
                       output logic [WW-1:0] ebyte, output logic [WW-1:0] eword);
    bit ok;
    ok = size >= 1 && size <= WW;
    eaddr = addr; epos = pos; ebyte = '0; eword = word;
    for (int i = 0; i < WW; i++)
      if (ok && i >= pos && i < pos + size) begin
        if (op == 2'b10) ebyte[i-pos] = word[i];
        if (op == 2'b11) eword[i] = data[i-pos];
      end
    if (op == 2'b01 && ok) begin
      if (pos >= size) epos = pos - size;
      else begin
        epos = WW - size;
        eaddr = (addr + 1) % (1 << AW);
      end
    end
  endtask

  task automatic run(string req, input logic [1:0] op, input int addr, input int pos,
                     input int size, input logic [WW-1:0] word, input logic [WW-1:0] data);
    int ea, ep;
    logic [WW-1:0] eb, ew;
    in_valid = 1'b1; in_op = op; in_addr = AW'(addr); in_pos = PW'(pos);
    in_size = PW'(size); in_word = word; st_data = data;
    @(negedge clk);
    in_valid = 1'b0;
    model(op, addr, pos, size, word, data, ea, ep, eb, ew);
    chk("R1", "out_valid", 64'(out_valid), 64'd1);
    chk(req, "out_addr", 64'(out_addr), 64'(ea));
    chk(req, "out_pos", 64'(out_pos), 64'(ep));
    chk(req, "out_byte", 64'(out_byte), 64'(eb));
    chk(req, "out_word", 64'(out_word), 64'(ew));
    chk("R9", "acc_addr", 64'(acc_addr), 64'(addr));
    chk("R9", "out_size", 64'(out_size), 64'(size));
  endtask

  task automatic walk(string req, int size, int n, int exp_pos[], int exp_addr[]);
    int a = 100, p = 36;
    for (int k = 0; k < n; k++) begin
      run(req, 2'b01, a, p, size, '0, '0);
      chk(req, "walk pos", 64'(out_pos), 64'(exp_pos[k]));
      chk(req, "walk addr", 64'(out_addr), 64'(exp_addr[k]));
      a = int'(out_addr); p = int'(out_pos);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1", "reset out_valid", 64'(out_valid), 64'd0);
    chk("R1", "reset out_word", 64'(out_word), 64'd0);
    chk("R1", "reset out_addr", 64'(out_addr), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle out_valid", 64'(out_valid), 64'd0);

    walk("R5", 7, 6, '{29, 22, 15, 8, 1, 29}, '{100, 100, 100, 100, 100, 101});
    walk("R5", 9, 5, '{27, 18, 9, 0, 27}, '{100, 100, 100, 100, 101});
    run("R3", 2'b01, 5, 36, 36, '0, '0);
    run("R4", 2'b01, (1 << AW) - 1, 0, 36, '0, '0);
    run("R4", 2'b01, 7, 3, 5, '0, '0);
    run("R2", 2'b00, 9, 12, 6, 36'h123456789, 36'hFFF);
    run("R6", 2'b10, 1, 0, 36, 36'hABCDEF012, '0);
    run("R6", 2'b10, 1, 29, 7, 36'hFE0000000, '0);
    run("R6", 2'b10, 1, 33, 6, 36'hE00000000, '0);
    run("R7", 2'b11, 2, 9, 9, 36'hFFFFFFFFF, 36'h000);
    run("R7", 2'b11, 2, 32, 8, 36'h000000000, 36'hFF);
    run("R7", 2'b11, 2, 0, 36, 36'h0F0F0F0F0, 36'h123456789);
    run("R8", 2'b10, 3, 4, 0, 36'hFFFFFFFFF, '0);
    run("R8", 2'b11, 3, 4, 40, 36'h0, 36'hFFFFFFFFF);
    run("R8", 2'b01, 3, 4, 37, '0, '0);
    chk("R1", "out_valid drops", 64'(out_valid), 64'd1);
    @(negedge clk);
    chk("R1", "out_valid drops", 64'(out_valid), 64'd0);

    for (int k = 0; k < 400; k++) begin
      int sz, ps;
      sz = ($urandom % 8 == 0) ? int'($urandom % 64) : int'($urandom % 36) + 1;
      ps = ($urandom % 8 == 0) ? int'($urandom % 64) : int'($urandom % 37);
      run("R6/R7 random", 2'($urandom), int'($urandom % (1 << AW)), ps, sz,
          {$urandom, $urandom} & {WW{1'b1}}, {$urandom, $urandom} & {WW{1'b1}});
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule